// File: doc/BRIEF.md
# Carry-Extended Integer Adder Unit

This block is the add/subtract slice of an integer execution stage. It takes two 64-bit operands, a 16-bit immediate and the incoming carry, overflow and summary-overflow bits. It then forms the 64-bit result with one of eight operations: plain add, subtract-from, add with carry, add minus one, subtract-from minus one, add carry only, shifted-immediate add, and subtract-from-immediate. Alongside the result it reports two carry bits, two overflow bits, the updated sticky summary-overflow bit and a four-bit condition field. Each carry and overflow bit pair covers both the 32-bit and the 64-bit boundary, and both are computed from the same addition.

The datapath is combinational and ends in one output register stage with a valid/ready handshake on each side. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its outputs appear with `out_valid` high after that edge. `in_ready` is high whenever the stage is empty or its contents are being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the stage holds its outputs unchanged and refuses new work.

Operation codes on `in_op`: 0 add, 1 subtract-from, 2 add-with-carry, 3 add-minus-one, 4 subtract-from-minus-one, 5 add-carry-only, 6 shifted-immediate add, 7 subtract-from-immediate.

Top module: `cx_adder_unit`

## Requirements
- R1: A beat is accepted when `in_valid` and `in_ready` are both high. Its outputs show with `out_valid` high from the next edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: After reset `out_valid` is 0 and `in_ready` is 1.
- R3: Op 0 gives A+B. Op 1 gives NOT A + B + 1. Both are taken modulo 2^64.
- R4: Op 2 gives A + B + ca_in[0]. Op 5 gives A + ca_in[0].
- R5: Op 3 gives A + all-ones + ca_in[0]. Op 4 gives NOT A + all-ones + ca_in[0].
- R6: Op 6 adds to A the 16-bit immediate placed at bits 31:16 and sign-extended above bit 31. When `in_a_zero` is 1, A reads as zero for op 6 only, and the flag has no effect on the other ops.
- R7: Op 7 gives NOT A + sign-extended immediate + 1.
- R8: For ops 2, 3, 4, 5 and 7, `out_ca[0]` is the carry out of bit 63 and `out_ca[1]` is the carry out of bit 31. For ops 0, 1 and 6, `out_ca` equals `in_ca`.
- R9: When `in_ov_en` is 1 and the op is 0 to 5, `out_ov[0]` is (carry out of bit 63 XOR result bit 63) AND (addend bit 63 values equal). `out_ov[1]` applies the same rule at bit 31. Otherwise `out_ov` equals `in_ov`.
- R10: `out_so` is `in_so` OR a newly computed `out_ov[0]`. A 32-bit-only overflow does not set it.
- R11: `out_cr0` bit 3 is result negative (bit 63), bit 2 is positive non-zero, bit 1 is result equal to zero over all 64 bits, and bit 0 is `out_so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation |
| in_op | input | 3 | Operation code |
| in_ov_en | input | 1 | Overflow-recording form |
| in_a_zero | input | 1 | Source A names the zero register |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_imm | input | 16 | Immediate field |
| in_ca | input | 2 | Incoming carry pair {CA32, CA} |
| in_ov | input | 2 | Incoming overflow pair {OV32, OV} |
| in_so | input | 1 | Incoming summary overflow |
| out_valid | output | 1 | Result held in the stage |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result |
| out_ca | output | 2 | Carry pair {CA32, CA} |
| out_ov | output | 2 | Overflow pair {OV32, OV} |
| out_so | output | 1 | Updated summary overflow |
| out_cr0 | output | 4 | {LT, GT, EQ, SO} |

## Verification
The bench builds the unit with its default parameters: a 64-bit word split at bit 32, and a 16-bit immediate shifted by 16. With these values the low-half carry and the full-width carry can be driven apart. This exposes cases where only OV32 or only OV rises, and where CA32 and CA differ. The shifted immediate also reaches bit 31, so its sign fill above bit 31 is tested directly. The vectors place operands at the signed and unsigned edges of both halves, and back-pressure is held over several cycles.

// File: rtl/cx_adder_pkg.sv
package cx_adder_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 3'd0,
    OP_SUBF   = 3'd1,
    OP_ADDC   = 3'd2,
    OP_ADDM1  = 3'd3,
    OP_SUBFM1 = 3'd4,
    OP_ADDCY  = 3'd5,
    OP_ADDSH  = 3'd6,
    OP_SUBFI  = 3'd7
  } add_op_e;

endpackage

// File: rtl/cx_operand_sel.sv
module cx_operand_sel
  import cx_adder_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 16,
  parameter int IMM_SHIFT = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic             a_zero,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm,
  input  logic             cy_in,
  output logic [XLEN-1:0]  add_x,
  output logic [XLEN-1:0]  add_y,
  output logic             add_cin,
  output logic             ca_owned,
  output logic             ov_owned
);

  localparam int SEXT_PAD = XLEN - IMM_W;
  localparam int HI_PAD   = XLEN - IMM_W - IMM_SHIFT;

  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] imm_high;
  logic [XLEN-1:0] a_or_zero;
  add_op_e         op_e;

  assign op_e      = add_op_e'(op);
  assign imm_sext  = {{SEXT_PAD{imm[IMM_W-1]}}, imm};
  assign imm_high  = {{HI_PAD{imm[IMM_W-1]}}, imm, {IMM_SHIFT{1'b0}}};
  assign a_or_zero = a_zero ? '0 : a;

  always_comb begin
    add_x    = a;
    add_y    = b;
    add_cin  = 1'b0;
    ca_owned = 1'b0;
    ov_owned = 1'b0;
    unique case (op_e)
      OP_ADD: begin
        ov_owned = 1'b1;
      end
      OP_SUBF: begin
        add_x    = ~a;
        add_cin  = 1'b1;
        ov_owned = 1'b1;
      end
      OP_ADDC: begin
        add_cin  = cy_in;
        ca_owned = 1'b1;
        ov_owned = 1'b1;
      end
      OP_ADDM1: begin
        add_y    = '1;
        add_cin  = cy_in;
        ca_owned = 1'b1;
        ov_owned = 1'b1;
      end
      OP_SUBFM1: begin
        add_x    = ~a;
        add_y    = '1;
        add_cin  = cy_in;
        ca_owned = 1'b1;
        ov_owned = 1'b1;
      end
      OP_ADDCY: begin
        add_y    = '0;
        add_cin  = cy_in;
        ca_owned = 1'b1;
        ov_owned = 1'b1;
      end
      OP_ADDSH: begin
        add_x    = a_or_zero;
        add_y    = imm_high;
      end
      OP_SUBFI: begin
        add_x    = ~a;
        add_y    = imm_sext;
        add_cin  = 1'b1;
        ca_owned = 1'b1;
      end
      default: begin
        add_x = a;
      end
    endcase
  end

endmodule

// File: rtl/cx_split_adder.sv
module cx_split_adder #(
  parameter int XLEN = 64,
  parameter int LO_W = 32
) (
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  input  logic            cin,
  output logic [XLEN-1:0] sum,
  output logic            c_lo,
  output logic            c_hi
);

  localparam int HI_W = XLEN - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  assign lo_sum = {1'b0, x[LO_W-1:0]} + {1'b0, y[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
  assign hi_sum = {1'b0, x[XLEN-1:LO_W]} + {1'b0, y[XLEN-1:LO_W]}
                + {{HI_W{1'b0}}, lo_sum[LO_W]};

  assign sum  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign c_lo = lo_sum[LO_W];
  assign c_hi = hi_sum[HI_W];

endmodule

// File: rtl/cx_flag_unit.sv
module cx_flag_unit #(
  parameter int XLEN = 64,
  parameter int LO_W = 32
) (
  input  logic [1:0]      x_msb,
  input  logic [1:0]      y_msb,
  input  logic [XLEN-1:0] sum,
  input  logic            c_lo,
  input  logic            c_hi,
  input  logic            ca_owned,
  input  logic            ov_live,
  input  logic [1:0]      ca_in,
  input  logic [1:0]      ov_in,
  input  logic            so_in,
  output logic [1:0]      ca_out,
  output logic [1:0]      ov_out,
  output logic            so_out,
  output logic [3:0]      cr0
);

  localparam int NBND = 2;

  logic [NBND-1:0] bnd_carry;
  logic [NBND-1:0] bnd_rmsb;
  logic [NBND-1:0] ov_raw;

  assign bnd_carry = {c_lo, c_hi};
  assign bnd_rmsb  = {sum[LO_W-1], sum[XLEN-1]};

  for (genvar k = 0; k < NBND; k++) begin : g_bnd
    assign ov_raw[k] = (bnd_carry[k] ^ bnd_rmsb[k]) & ~(x_msb[k] ^ y_msb[k]);
  end

  logic is_zero;
  logic is_neg;

  assign ca_out  = ca_owned ? bnd_carry : ca_in;
  assign ov_out  = ov_live ? ov_raw : ov_in;
  assign so_out  = so_in | (ov_live & ov_raw[0]);
  assign is_zero = (sum == '0);
  assign is_neg  = sum[XLEN-1];
  assign cr0     = {is_neg, ~is_neg & ~is_zero, is_zero, so_out};

endmodule

// File: rtl/cx_adder_unit.sv
module cx_adder_unit
  import cx_adder_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LO_W      = 32,
  parameter int IMM_W     = 16,
  parameter int IMM_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic             in_ov_en,
  input  logic             in_a_zero,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [1:0]       in_ca,
  input  logic [1:0]       in_ov,
  input  logic             in_so,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic [1:0]       out_ca,
  output logic [1:0]       out_ov,
  output logic             out_so,
  output logic [3:0]       out_cr0
);

  logic [XLEN-1:0] add_x, add_y, sum;
  logic            add_cin, ca_owned, ov_owned, c_lo, c_hi;
  logic [1:0]      ca_n, ov_n;
  logic            so_n;
  logic [3:0]      cr0_n;
  logic            accept;

  cx_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W), .IMM_SHIFT(IMM_SHIFT)) u_sel (
    .op(in_op), .a_zero(in_a_zero), .a(in_a), .b(in_b), .imm(in_imm),
    .cy_in(in_ca[0]), .add_x(add_x), .add_y(add_y), .add_cin(add_cin),
    .ca_owned(ca_owned), .ov_owned(ov_owned)
  );

  cx_split_adder #(.XLEN(XLEN), .LO_W(LO_W)) u_add (
    .x(add_x), .y(add_y), .cin(add_cin), .sum(sum), .c_lo(c_lo), .c_hi(c_hi)
  );

  cx_flag_unit #(.XLEN(XLEN), .LO_W(LO_W)) u_flag (
    .x_msb({add_x[LO_W-1], add_x[XLEN-1]}),
    .y_msb({add_y[LO_W-1], add_y[XLEN-1]}),
    .sum(sum), .c_lo(c_lo), .c_hi(c_hi), .ca_owned(ca_owned),
    .ov_live(ov_owned & in_ov_en), .ca_in(in_ca), .ov_in(in_ov), .so_in(in_so),
    .ca_out(ca_n), .ov_out(ov_n), .so_out(so_n), .cr0(cr0_n)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ca     <= '0;
      out_ov     <= '0;
      out_so     <= 1'b0;
      out_cr0    <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= sum;
        out_ca     <= ca_n;
        out_ov     <= ov_n;
        out_so     <= so_n;
        out_cr0    <= cr0_n;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R1: accepted work shows next cycle; stalled output is frozen
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_cr0)));

  // R11: condition field consistent with stored result and summary bit
  p_cr0_so_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cr0[0] == out_so));
  p_cr0_eq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cr0[1] == (out_result == '0)));
  p_cr0_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_cr0[3:1]) == 1));

  // R10: a summary bit offered as set is never cleared
  p_so_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_so) |=> out_so);

endmodule

// File: tb/test_cx_adder_unit.sv
module test_cx_adder_unit;

  localparam int XLEN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_ov_en = 1'b0;
  logic        in_a_zero = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [15:0] in_imm = '0;
  logic [1:0]  in_ca = '0;
  logic [1:0]  in_ov = '0;
  logic        in_so = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [1:0]  out_ca;
  logic [1:0]  out_ov;
  logic        out_so;
  logic [3:0]  out_cr0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cx_adder_unit i_cx_adder_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_ov_en(in_ov_en), .in_a_zero(in_a_zero), .in_a(in_a),
    .in_b(in_b), .in_imm(in_imm), .in_ca(in_ca), .in_ov(in_ov), .in_so(in_so),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_ca(out_ca), .out_ov(out_ov), .out_so(out_so), .out_cr0(out_cr0)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        oven;
    logic        azero;
    logic [1:0]  ca;
    logic [1:0]  ov;
    logic        so;
    logic [63:0] a;
    logic [63:0] b;
    logic [15:0] imm;
    logic [63:0] x_res;
    logic [1:0]  x_ca;
    logic [1:0]  x_ov;
    logic        x_so;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R3 plain add, no flags
    '{3'd0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h1, 64'h2, 16'h0,
      64'h3, 2'b00, 2'b00, 1'b0},
    // R3 R8 R9 R10 64-bit overflow, carry pair passes through
    '{3'd0, 1'b1, 1'b0, 2'b10, 2'b00, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0,
      64'h8000_0000_0000_0000, 2'b10, 2'b01, 1'b1},
    // R3 subtract-from, sticky SO kept
    '{3'd1, 1'b1, 1'b0, 2'b01, 2'b00, 1'b1, 64'h10, 64'h5, 16'h0,
      64'hFFFF_FFFF_FFFF_FFF5, 2'b01, 2'b00, 1'b1},
    // R4 R8 add-with-carry wraps to zero
    '{3'd2, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0,
      64'h0, 2'b11, 2'b00, 1'b0},
    // R4 add-carry-only, no carry in
    '{3'd5, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h00FF_00FF_00FF_0080, 64'h0, 16'h0,
      64'h00FF_00FF_00FF_0080, 2'b00, 2'b00, 1'b0},
    // R5 add-minus-one from zero
    '{3'd3, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h0, 64'h0, 16'h0,
      64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 2'b00, 1'b0},
    // R5 R8 add-minus-one with carry in returns A, both carries
    '{3'd3, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 64'h7_FFFF_FFFF, 64'h0, 16'h0,
      64'h7_FFFF_FFFF, 2'b11, 2'b00, 1'b0},
    // R5 R8 R9 only the upper carry, 64-bit overflow
    '{3'd3, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 16'h0,
      64'h7FFF_FFFF_FFFF_FFFF, 2'b01, 2'b01, 1'b1},
    // R5 subtract-from-minus-one
    '{3'd4, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 64'h0, 64'h0, 16'h0,
      64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 2'b00, 1'b0},
    // R6 R8 R9 shifted immediate with zero source; flags pass through
    '{3'd6, 1'b1, 1'b1, 2'b11, 2'b10, 1'b0, 64'h5, 64'h0, 16'h0001,
      64'h1_0000, 2'b11, 2'b10, 1'b0},
    // R6 negative shifted immediate
    '{3'd6, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h100, 64'h0, 16'h8000,
      64'hFFFF_FFFF_8000_0100, 2'b00, 2'b00, 1'b0},
    // R7 R8 subtract-from-immediate, OV passes through
    '{3'd7, 1'b1, 1'b0, 2'b00, 2'b01, 1'b0, 64'h1, 64'h0, 16'h0005,
      64'h4, 2'b11, 2'b01, 1'b0},
    // R7 negative immediate
    '{3'd7, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h10, 64'h0, 16'hFFFF,
      64'hFFFF_FFFF_FFFF_FFEF, 2'b11, 2'b00, 1'b0},
    // R9 overflow not recorded when disabled
    '{3'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 16'h0,
      64'h8000_0000_0000_0000, 2'b00, 2'b00, 1'b0},
    // R9 R10 32-bit-only overflow leaves SO clear
    '{3'd0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 64'h7FFF_FFFF, 64'h1, 16'h0,
      64'h8000_0000, 2'b00, 2'b10, 1'b0},
    // R4 add-with-carry small values
    '{3'd2, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 64'h1, 64'h2, 16'h0,
      64'h4, 2'b00, 2'b00, 1'b0},
    // R6 zero-source flag ignored outside shifted immediate
    '{3'd0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, 64'h3, 64'h4, 16'h0,
      64'h7, 2'b00, 2'b00, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] cr_of(input logic [63:0] r, input logic s);
    logic neg, zer;
    neg = r[63];
    zer = (r == 64'h0);
    return {neg, !neg && !zer, zer, s};
  endfunction

  task automatic drive(input vec_t v);
    in_op = v.op; in_ov_en = v.oven; in_a_zero = v.azero; in_ca = v.ca;
    in_ov = v.ov; in_so = v.so; in_a = v.a; in_b = v.b; in_imm = v.imm;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    vec_t hv;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    chk("R2 out_valid in reset", {63'b0, out_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 in_ready after reset", {63'b0, in_ready}, 64'h1);
    chk("R2 out_valid after reset", {63'b0, out_valid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R1 valid v%0d", i), {63'b0, out_valid}, 64'h1);
      chk($sformatf("R3-7 result v%0d", i), out_result, VECS[i].x_res);
      chk($sformatf("R8 carry v%0d", i), {62'b0, out_ca}, {62'b0, VECS[i].x_ca});
      chk($sformatf("R9 overflow v%0d", i), {62'b0, out_ov}, {62'b0, VECS[i].x_ov});
      chk($sformatf("R10 so v%0d", i), {63'b0, out_so}, {63'b0, VECS[i].x_so});
      chk($sformatf("R11 cr0 v%0d", i), {60'b0, out_cr0},
          {60'b0, cr_of(VECS[i].x_res, VECS[i].x_so)});
    end

    // R1 back-pressure: stage fills, refuses, holds
    @(negedge clk);
    out_ready = 1'b0;
    hv = VECS[1];
    drive(hv);
    in_valid = 1'b1;
    @(negedge clk);
    held = out_result;
    chk("R1 full stage not ready", {63'b0, in_ready}, 64'h0);
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    chk("R1 held result", out_result, hv.x_res);
    chk("R1 held valid", {63'b0, out_valid}, 64'h1);
    chk("R1 stable while stalled", out_result, held);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 next beat after release", out_result, 64'h3);
    @(negedge clk);
    chk("R1 drained", {63'b0, out_valid}, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule